// File: doc/BRIEF.md
# ADC Sample Sequencer FIFO

This block holds the result queues of a set of converter sample sequencers. Each sequencer owns a 16-entry result queue whose state is visible as one packed status word carrying the read pointer, the write pointer and the empty and full flags. Software programs an active-sequencer enable, an interrupt mask, and per-sequencer channel-mux and control words, and drains results by reading a pop location. All of these sit in a small byte-addressed register window; the per-sequencer groups start at offset 0x40 and repeat every 32 bytes.

Conversions come from a trigger input. While sequencer 0 is enabled, each trigger cycle advances a 32-bit linear congruential noise state and pushes one synthetic sample derived from it into sequencer 0's queue, and also raises interrupt bit 0. The interrupt output follows raw status gated by the mask. Sequencers 1 and above have their register groups and queues, but nothing feeds them.

Register map (byte offsets): 0x00 active enable (low 4 bits kept), 0x04 interrupt mask (low 4 bits), 0x08 raw status (read only), 0x0C masked status on read and write-1-to-clear of raw status on write. Per sequencer n at 0x40 + 32n: +0x0 mux, +0x4 control, +0x8 pop (read returns head entry and pops), +0xC status. Unmapped reads return zero. Reads are combinational in the cycle the select is high; every state change lands at the following clock edge.

Top module: `adc_seq_fifo`

## Requirements
- R1: After reset every status word reads 0x100 (empty flag set, both pointers zero), raw status, mask and active enable read 0, every queue entry is 0, and irq_o is low.
- R2: The active enable keeps only bits 3:0 of a write; a trigger cycle while bit 0 of the active enable is clear changes neither raw status nor sequencer 0's status word.
- R3: On each accepted trigger the noise state (reset value 0) becomes state*314159+1 modulo 2^32, and the sample pushed is 0x200 plus bits 18:16 of that new state.
- R4: A push into a non-full queue stores the sample at the write pointer, advances it modulo 16, clears empty, and sets full when the pointers become equal; the status word holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12, other bits zero.
- R5: A push into a full queue is dropped: contents and status word are unchanged, while the noise state still advances and raw bit 0 is still set.
- R6: A pop from a non-empty queue returns the entry at the read pointer, clears full, advances the read pointer modulo 16, and sets empty when it then equals the write pointer.
- R7: A pop from an empty queue returns the entry at the read pointer and changes no state.
- R8: Each accepted trigger sets raw bit 0; the masked-status read is raw AND mask and irq_o is high exactly while that is nonzero.
- R9: Writing the clear location clears the raw bits written as 1; a trigger accepted in the same cycle leaves raw bit 0 set.
- R10: The mux register keeps only the bits selected by 0x33333333; the control register keeps all 32 bits.
- R11: A pop and a push to sequencer 0 in the same cycle act as the pop followed by the push, so a full queue accepts the new sample and stays full, and an empty queue takes the sample without any pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Conversion trigger, one sample per high cycle |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt, high while raw AND mask is nonzero |

## Verification
A corrupted pointer or flag shows up in the status word on the very next read and in the value returned by the following pop, so the reference model compares every read and the interrupt line on every cycle. A drift in the noise state appears as a wrong sample value on the first pop after the faulty trigger, and a mis-ordered pop/push or dropped-push decision is caught when the queue is driven full and empty and drained back to its exact expected contents.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [31:0] LCG_MUL  = 32'd314159;
  localparam logic [31:0] LCG_INC  = 32'd1;
  localparam logic [11:0] SAMPLE_BASE = 12'h200;

  function automatic logic [31:0] lcg_next(input logic [31:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction

  // pointer fields are 4 bits wide; flags sit at bits 8 and 12
  function automatic logic [31:0] pack_status(input logic [3:0] rp, input logic [3:0] wp,
                                               input logic empty, input logic full);
    return {19'd0, full, 3'd0, empty, wp, rp};
  endfunction
endpackage

// File: rtl/adc_seq_noise.sv
module adc_seq_noise #(
  parameter int SW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [SW-1:0] sample_o
);
  import adc_seq_pkg::*;
  logic [31:0] state_q, state_n;

  assign state_n  = lcg_next(state_q);
  assign sample_o = SW'(SAMPLE_BASE) | SW'(state_n[18:16]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (step_i) state_q <= state_n;
  end
endmodule

// File: rtl/adc_seq_buf.sv
module adc_seq_buf #(
  parameter int DEPTH = 16,
  parameter int SW    = 10,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [SW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [SW-1:0] head_o,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] wptr_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [SW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rptr_q, wptr_q, rptr_n, wptr_n;
  logic          empty_q, full_q, empty_n, full_n, wr_en;

  // pop resolves first, push sees the post-pop state
  always_comb begin
    rptr_n  = rptr_q;
    wptr_n  = wptr_q;
    empty_n = empty_q;
    full_n  = full_q;
    wr_en   = 1'b0;
    if (pop_i && !empty_q) begin
      rptr_n  = rptr_q + PW'(1);
      full_n  = 1'b0;
      empty_n = (rptr_n == wptr_q);
    end
    if (push_i && !full_n) begin
      wr_en   = 1'b1;
      wptr_n  = wptr_q + PW'(1);
      empty_n = 1'b0;
      full_n  = (wptr_n == rptr_n);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      rptr_q  <= rptr_n;
      wptr_q  <= wptr_n;
      empty_q <= empty_n;
      full_q  <= full_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wptr_q] <= push_data_i;
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign rptr_o  = rptr_q;
  assign wptr_o  = wptr_q;
  assign empty_o = empty_q;
  assign full_o  = full_q;
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int NUM_SEQ = 4,
  parameter int DEPTH   = 16,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int SW      = 10,
  parameter int NIRQ    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  import adc_seq_pkg::*;

  localparam int PW         = $clog2(DEPTH);
  localparam int SEQ_BASE   = 'h40;
  localparam int SEQ_STRIDE = 32;
  localparam int SEQ_TOP    = SEQ_BASE + SEQ_STRIDE * NUM_SEQ;
  localparam logic [DW-1:0] MUX_KEEP = {(DW/8){8'h33}};
  localparam logic [AW-1:0] A_ACT  = AW'('h00);
  localparam logic [AW-1:0] A_MASK = AW'('h04);
  localparam logic [AW-1:0] A_RAW  = AW'('h08);
  localparam logic [AW-1:0] A_MSK  = AW'('h0C);
  localparam logic [4:0] O_MUX = 5'h00, O_CTL = 5'h04, O_POP = 5'h08, O_STAT = 5'h0C;

  logic [NIRQ-1:0] active_q, mask_q, raw_q, raw_n;
  logic            wr_w, rd_w, in_seq, trig_acc;
  logic [AW-1:0]   rel;
  logic [4:0]      seq_off;
  logic [NUM_SEQ-1:0] hit_w, pop_w;
  logic [DW-1:0]   mux_w  [NUM_SEQ];
  logic [DW-1:0]   ctl_w  [NUM_SEQ];
  logic [DW-1:0]   stat_w [NUM_SEQ];
  logic [SW-1:0]   head_w [NUM_SEQ];
  logic [SW-1:0]   sample_w;

  assign wr_w     = bus_sel_i && bus_wr_i;
  assign rd_w     = bus_sel_i && !bus_wr_i;
  assign rel      = bus_addr_i - AW'(SEQ_BASE);
  assign seq_off  = rel[4:0];
  assign in_seq   = (int'(bus_addr_i) >= SEQ_BASE) && (int'(bus_addr_i) < SEQ_TOP);
  assign trig_acc = trig_i && active_q[0];

  adc_seq_noise #(.SW(SW)) u_noise (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(trig_acc), .sample_o(sample_w)
  );

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    logic [DW-1:0] mux_q, ctl_q;
    logic [PW-1:0] rp, wp;
    logic          em, fu;

    assign hit_w[g] = in_seq && (int'(rel[AW-1:5]) == g);
    assign pop_w[g] = rd_w && hit_w[g] && (seq_off == O_POP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mux_q <= '0;
        ctl_q <= '0;
      end else if (wr_w && hit_w[g]) begin
        if (seq_off == O_MUX) mux_q <= bus_wdata_i & MUX_KEEP;
        if (seq_off == O_CTL) ctl_q <= bus_wdata_i;
      end
    end

    adc_seq_buf #(.DEPTH(DEPTH), .SW(SW)) u_buf (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .push_i((g == 0) ? trig_acc : 1'b0),
      .push_data_i(sample_w),
      .pop_i(pop_w[g]),
      .head_o(head_w[g]),
      .rptr_o(rp), .wptr_o(wp), .empty_o(em), .full_o(fu)
    );

    assign mux_w[g]  = mux_q;
    assign ctl_w[g]  = ctl_q;
    assign stat_w[g] = DW'(pack_status(4'(rp), 4'(wp), em, fu));
  end

  always_comb begin
    raw_n = raw_q;
    if (wr_w && bus_addr_i == A_MSK) raw_n = raw_q & ~bus_wdata_i[NIRQ-1:0];
    if (trig_acc) raw_n[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
    end else begin
      raw_q <= raw_n;
      if (wr_w && bus_addr_i == A_ACT)  active_q <= bus_wdata_i[NIRQ-1:0];
      if (wr_w && bus_addr_i == A_MASK) mask_q   <= bus_wdata_i[NIRQ-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (in_seq) begin
      for (int s = 0; s < NUM_SEQ; s++) begin
        if (hit_w[s]) begin
          case (seq_off)
            O_MUX:   bus_rdata_o = mux_w[s];
            O_CTL:   bus_rdata_o = ctl_w[s];
            O_POP:   bus_rdata_o = DW'(head_w[s]);
            O_STAT:  bus_rdata_o = stat_w[s];
            default: bus_rdata_o = '0;
          endcase
        end
      end
    end else begin
      case (bus_addr_i)
        A_ACT:   bus_rdata_o = DW'(active_q);
        A_MASK:  bus_rdata_o = DW'(mask_q);
        A_RAW:   bus_rdata_o = DW'(raw_q);
        A_MSK:   bus_rdata_o = DW'(raw_q & mask_q);
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(raw_q & mask_q);
endmodule

// File: rtl/adc_seq_fifo_chk.sv
module adc_seq_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trig_i,
  input logic        irq_o,
  input logic [3:0]  active_i,
  input logic [3:0]  mask_i,
  input logic [3:0]  raw_i,
  input logic        pop0_i,
  input logic [31:0] stat0_i
);
  AST_ACCEPT_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && active_i[0]) |=> raw_i[0]); // R8
  AST_IDLE_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(trig_i && active_i[0]) && !pop0_i) |=> $stable(stat0_i)); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat0_i[8] && stat0_i[12])); // R4
  AST_FULL_PTR_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat0_i[12] |-> (stat0_i[3:0] == stat0_i[7:4])); // R5
  AST_EMPTY_PTR_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat0_i[8] |-> (stat0_i[3:0] == stat0_i[7:4])); // R6
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop0_i && stat0_i[8] && !(trig_i && active_i[0])) |=> $stable(stat0_i)); // R7
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_i != 4'd0)); // R8
endmodule

bind adc_seq_fifo adc_seq_fifo_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .irq_o(irq_o),
  .active_i(active_q), .mask_i(mask_q), .raw_i(raw_q),
  .pop0_i(pop_w[0]), .stat0_i(stat_w[0])
);

// File: tb/adc_seq_fifo_tb.sv
module adc_seq_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  adc_seq_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference state
  bit [9:0]  m_mem [4][16];
  int        m_rp [4];
  int        m_wp [4];
  int        m_cnt [4];
  bit [31:0] m_mux [4];
  bit [31:0] m_ctl [4];
  bit [3:0]  m_act, m_mask, m_raw;
  bit [31:0] m_noise;

  function automatic bit [31:0] m_status(int s);
    bit [31:0] v = 0;
    v[3:0] = 4'(m_rp[s]);
    v[7:4] = 4'(m_wp[s]);
    v[8]   = (m_cnt[s] == 0);
    v[12]  = (m_cnt[s] == 16);
    return v;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    if (a >= 8'h40 && a < 8'hC0) begin
      int s = (int'(a) - 64) / 32;
      int o = int'(a) % 32;
      case (o)
        0: return m_mux[s];
        4: return m_ctl[s];
        8: return 32'(m_mem[s][m_rp[s]]);
        12: return m_status(s);
        default: return 0;
      endcase
    end
    case (a)
      8'h00: return 32'(m_act);
      8'h04: return 32'(m_mask);
      8'h08: return 32'(m_raw);
      8'h0C: return 32'(m_raw & m_mask);
      default: return 0;
    endcase
  endfunction

  task automatic m_step(bit s_sel, bit s_wr, bit [7:0] a, bit [31:0] d, bit tg);
    bit acc = tg && m_act[0];
    bit [3:0] clr = 0;
    if (s_sel && !s_wr && a >= 8'h40 && a < 8'hC0 && (int'(a) % 32) == 8) begin
      int s = (int'(a) - 64) / 32;
      if (m_cnt[s] > 0) begin
        m_rp[s] = (m_rp[s] + 1) % 16;
        m_cnt[s]--;
      end
    end
    if (acc) begin
      bit [9:0] smp;
      m_noise = m_noise * 32'd314159 + 32'd1;
      smp = 10'h200 + 10'((m_noise >> 16) & 7);
      if (m_cnt[0] < 16) begin
        m_mem[0][m_wp[0]] = smp;
        m_wp[0] = (m_wp[0] + 1) % 16;
        m_cnt[0]++;
      end
    end
    if (s_sel && s_wr) begin
      if (a >= 8'h40 && a < 8'hC0) begin
        int s = (int'(a) - 64) / 32;
        if ((int'(a) % 32) == 0) m_mux[s] = d & 32'h3333_3333;
        if ((int'(a) % 32) == 4) m_ctl[s] = d;
      end else begin
        if (a == 8'h00) m_act  = d[3:0];
        if (a == 8'h04) m_mask = d[3:0];
        if (a == 8'h0C) clr    = d[3:0];
      end
    end
    m_raw = m_raw & ~clr;
    if (acc) m_raw[0] = 1'b1;
  endtask

  task automatic chk(string tag, bit [31:0] got, bit [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit s_sel, bit s_wr, bit [7:0] a, bit [31:0] d, bit tg, string tag);
    @(negedge clk);
    sel = s_sel; wr = s_wr; addr = a; wdata = d; trig = tg;
    #1;
    if (s_sel && !s_wr) chk(tag, rdata, m_read(a));
    chk({tag, "/R8 irq"}, 32'(irq), 32'(|(m_raw & m_mask)));
    m_step(s_sel, s_wr, a, d, tg);
  endtask

  task automatic rd(bit [7:0] a, string tag);  cyc(1, 0, a, 0, 0, tag); endtask
  task automatic wrr(bit [7:0] a, bit [31:0] d, string tag); cyc(1, 1, a, d, 0, tag); endtask
  task automatic trg(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_rp[s] = 0; m_wp[s] = 0; m_cnt[s] = 0; m_mux[s] = 0; m_ctl[s] = 0;
      for (int e = 0; e < 16; e++) m_mem[s][e] = 0;
    end
    m_act = 0; m_mask = 0; m_raw = 0; m_noise = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h4C, "R1 stat0"); rd(8'h6C, "R1 stat1");
    rd(8'h8C, "R1 stat2"); rd(8'hAC, "R1 stat3");
    rd(8'h08, "R1 raw"); rd(8'h00, "R1 act"); rd(8'h04, "R1 mask");
    rd(8'h4C, "R1 stat0 again");

    // R2 active width and ignored trigger
    wrr(8'h00, 32'hFFF5, "R2");
    rd(8'h00, "R2 act keeps 4 bits");
    wrr(8'h00, 32'h0E, "R2");
    trg(3, "R2");
    rd(8'h4C, "R2 stat0 untouched");
    rd(8'h08, "R2 raw untouched");

    // R3 R4 R8 first accepted trigger
    wrr(8'h00, 32'h1, "R2");
    trg(1, "R4");
    rd(8'h4C, "R4 stat after push");
    rd(8'h08, "R8 raw set");
    rd(8'h0C, "R8 masked zero");
    wrr(8'h04, 32'h1, "R8");
    rd(8'h0C, "R8 masked set");
    rd(8'h48, "R3 first sample");
    rd(8'h4C, "R6 stat after pop");

    // R9 clear, and clear vs trigger
    wrr(8'h0C, 32'h1, "R9");
    rd(8'h08, "R9 raw cleared");
    cyc(1, 1, 8'h0C, 32'hF, 1, "R9");
    rd(8'h08, "R9 set wins");

    // R5 fill past full, R6 drain, R7 empty pops
    trg(20, "R5");
    rd(8'h4C, "R5 full stat");
    for (int i = 0; i < 16; i++) rd(8'h48, "R6 drain");
    rd(8'h4C, "R6 empty stat");
    rd(8'h48, "R7 empty pop");
    rd(8'h48, "R7 empty pop repeat");
    rd(8'h4C, "R7 stat unchanged");
    rd(8'h68, "R7 seq1 empty pop");
    rd(8'h6C, "R7 seq1 stat");

    // R10 mux and control masks
    wrr(8'h40, 32'hFFFF_FFFF, "R10"); rd(8'h40, "R10 mux0");
    wrr(8'h80, 32'hA5C3_9F1E, "R10"); rd(8'h80, "R10 mux2");
    wrr(8'h44, 32'hDEAD_BEEF, "R10"); rd(8'h44, "R10 ctl0");
    rd(8'hA4, "R10 ctl3 untouched");

    // R11 simultaneous pop and push: empty then full
    cyc(1, 0, 8'h48, 0, 1, "R11 pop+push empty");
    rd(8'h4C, "R11 stat after empty case");
    trg(16, "R11 fill");
    rd(8'h4C, "R11 full before");
    cyc(1, 0, 8'h48, 0, 1, "R11 pop+push full");
    rd(8'h4C, "R11 still full");
    for (int i = 0; i < 16; i++) rd(8'h48, "R11 drain");
    rd(8'h4C, "R11 empty after");

    // R2 disable again, trigger ignored with interrupt mask set
    wrr(8'h0C, 32'h1, "R9");
    wrr(8'h00, 32'h0, "R2");
    trg(2, "R2");
    rd(8'h08, "R2 raw still clear");
    rd(8'h4C, "R2 stat still empty");

    cyc(0, 0, 0, 0, 0, "R8 idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule